// File: doc/BRIEF.md
# Square-Wave and Pulse Interval Timer

The block is a down-counting interval timer. A timer-input strobe, one system-clock cycle wide per input period, drives it. Software first fills a 16-bit staging register one byte at a time. Its low 14 bits hold the cycle length and its top two bits select the waveform. A START command then copies that value into the live counter. The counter moves down by two on each strobe and runs through its range twice per output cycle: once for the high half and once for the low half. This lets it produce a square wave whose odd lengths split unevenly. The other waveform is a one-period low pulse at the end of each cycle. Both waveforms exist in a one-shot form and a self-reloading form.

Writes to the staging register never disturb a running cycle; only START adopts them. The live counter and the active mode can always be read back. The raw value does not equal the number of strobes received, because of the two passes. STOP freezes the counter at once. A deferred stop finishes the current cycle first. Reset halts the timer without clearing or loading the counter. Every pin is a plain control or status level. No data stream crosses the block's edge, so there is no handshake and no back-pressure.

Top module: `sqp_timer`

## Requirements
- R1: Staging writes take `wr_data_i` into bits 7:0 when `wr_hi_i` is 0 and into bits 15:8 when it is 1. Bits 13:0 hold the length n and bits 15:14 the mode: bit 15 = pulse form, bit 14 = auto-reload. `cnt_rd_o` reads back {active mode, live counter}.
- R2: Commands on `cmd_i` when `cmd_valid_i` is 1 are 00 no-op, 01 stop now, 10 stop at terminal count, 11 start. A legal start makes `cnt_rd_o` read {staged mode, n} on the next cycle.
- R3: Each strobe while running lowers the counter by two. The first half starts at n and ends on the strobe seen with the counter at or below 2. The second half starts at n rounded down to even and ends the cycle on the strobe seen at 2.
- R4: In square modes the output is high for ceil(n/2) strobe periods and then low for floor(n/2); n = 9 gives 5 high and 4 low.
- R5: Mode 00 runs one square cycle. After n strobes the timer stops with the output high and the counter holding 2.
- R6: Mode 01 reloads n at each terminal count and repeats without end.
- R7: In pulse modes the output is low only between the (n-1)th and nth strobe of a cycle. Mode 10 stops after one cycle; mode 11 repeats.
- R8: Staging writes while running change neither the output nor the readback. A later start restarts the timer with the new length and mode.
- R9: While stopped the output is high and the readback holds still, whatever the strobes do.
- R10: A deferred stop lets the running cycle finish. At its terminal count the timer stops with the counter at 2, even in a reload mode.
- R11: A start with n below 2 leaves the timer stopped with the output high. The counter and mode are not loaded.
- R12: Reset stops the timer and forces the output high. The counter and mode keep their values, and only a new start resumes counting.
- R13: When a command meets a strobe in the same cycle, start loads and the strobe is ignored, and stop-now freezes and the strobe is ignored. A deferred stop that arrives with the terminal-count strobe stops at that terminal count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Timer-input strobe, one cycle per input period |
| wr_en_i | input | 1 | Staging register byte write enable |
| wr_hi_i | input | 1 | Selects upper (1) or lower (0) staging byte |
| wr_data_i | input | 8 | Staging byte data |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_i | input | 2 | Command code |
| timer_out_o | output | 1 | Timer waveform output |
| cnt_rd_o | output | 16 | {active mode, live counter} readback |

## Verification
A strobe and a command can land on the same clock edge. That collision decides whether the count moves or is frozen, reloaded or stopped. The bench drives the command and the strobe together in one cycle for start, for stop-now, and for a deferred stop on the terminal-count strobe. It then compares output and readback on the next cycle with a model that counts only the strobes the requirements let through. Random runs of varied length, mode and strobe spacing, held against the same model, cover the ordinary counting paths around these collisions.

// File: rtl/sqp_timer_pkg.sv
package sqp_timer_pkg;
  typedef enum logic [1:0] {
    CMD_NOP     = 2'b00,
    CMD_STOP    = 2'b01,
    CMD_STOP_TC = 2'b10,
    CMD_START   = 2'b11
  } sqp_cmd_e;

  localparam int MODE_W          = 2;
  localparam int MODE_PULSE_BIT  = 1;
  localparam int MODE_RELOAD_BIT = 0;
endpackage

// File: rtl/sqp_cfg_stage.sv
module sqp_cfg_stage #(
  parameter int REG_W = 16
) (
  input  logic                 clk,
  input  logic                 wr_en_i,
  input  logic                 wr_hi_i,
  input  logic [REG_W/2-1:0]   wr_data_i,
  output logic [REG_W-1:0]     stage_o
);
  localparam int HALF_W = REG_W / 2;

  logic [REG_W-1:0] stage_q;

  // Staged value is data only: no reset, adopted solely by START.
  always_ff @(posedge clk) begin
    if (wr_en_i) begin
      if (wr_hi_i) stage_q[REG_W-1:HALF_W] <= wr_data_i;
      else         stage_q[HALF_W-1:0]     <= wr_data_i;
    end
  end

  assign stage_o = stage_q;
endmodule

// File: rtl/sqp_down_core.sv
module sqp_down_core
  import sqp_timer_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_i,
  input  logic [CNT_W-1:0]  stage_len_i,
  input  logic [MODE_W-1:0] stage_mode_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              phase_o,
  output logic              run_o
);
  localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

  logic              run_q, phase_q, pend_q;
  logic [CNT_W-1:0]  cnt_q, len_q;
  logic [MODE_W-1:0] mode_q;

  logic do_start, do_stop, do_stop_tc, legal, step, half_end, keep_going;

  assign do_start   = cmd_valid_i && (cmd_i == CMD_START);
  assign do_stop    = cmd_valid_i && (cmd_i == CMD_STOP);
  assign do_stop_tc = cmd_valid_i && (cmd_i == CMD_STOP_TC);
  assign legal      = stage_len_i >= TWO;
  assign step       = run_q && tick_i && !do_start && !do_stop;
  assign half_end   = cnt_q <= TWO;
  assign keep_going = mode_q[MODE_RELOAD_BIT] && !pend_q && !do_stop_tc;

  // Control state: the only registers touched by reset.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      phase_q <= 1'b0;
      pend_q  <= 1'b0;
    end else if (do_start) begin
      run_q   <= legal;
      phase_q <= 1'b0;
      pend_q  <= 1'b0;
    end else if (do_stop) begin
      run_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (do_stop_tc && run_q) pend_q <= 1'b1;
      if (step && half_end) begin
        phase_q <= !phase_q;
        if (phase_q) begin
          pend_q <= 1'b0;
          if (!keep_going) run_q <= 1'b0;
        end
      end
    end
  end

  // Count, length and mode: kept across reset, loaded only by a legal START.
  always_ff @(posedge clk) begin
    if (rst_n) begin
      if (do_start && legal) begin
        cnt_q  <= stage_len_i;
        len_q  <= stage_len_i;
        mode_q <= stage_mode_i;
      end else if (step) begin
        if (!half_end)      cnt_q <= cnt_q - TWO;
        else if (!phase_q)  cnt_q <= {len_q[CNT_W-1:1], 1'b0};
        else if (keep_going) cnt_q <= len_q;
      end
    end
  end

  assign cnt_o   = cnt_q;
  assign mode_o  = mode_q;
  assign phase_o = phase_q;
  assign run_o   = run_q;

  // R9
  stopped_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !do_start) |=> $stable(cnt_q));

  // R11
  illegal_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (do_start && !legal) |=> !run_q);

  // R13
  stop_beats_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (do_stop && tick_i) |=> (!run_q && $stable(cnt_q)));

  // R3
  even_low_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && phase_q) |-> !cnt_q[0]);

  // R3
  nonzero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q != '0));
endmodule

// File: rtl/sqp_out_shaper.sv
module sqp_out_shaper
  import sqp_timer_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              phase_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic              timer_out_o
);
  logic last_period;

  assign last_period = phase_i && (cnt_i == CNT_W'(2));

  always_comb begin
    if (!run_i)                   timer_out_o = 1'b1;
    else if (mode_i[MODE_PULSE_BIT]) timer_out_o = !last_period;
    else                          timer_out_o = !phase_i;
  end

  // R9
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |-> timer_out_o);

  // R7
  pulse_single_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && mode_i[MODE_PULSE_BIT] && !timer_out_o) |-> (phase_i && !cnt_i[0]));
endmodule

// File: rtl/sqp_timer.sv
module sqp_timer
  import sqp_timer_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        tick_i,
  input  logic                        wr_en_i,
  input  logic                        wr_hi_i,
  input  logic [(CNT_W+MODE_W)/2-1:0] wr_data_i,
  input  logic                        cmd_valid_i,
  input  logic [1:0]                  cmd_i,
  output logic                        timer_out_o,
  output logic [CNT_W+MODE_W-1:0]     cnt_rd_o
);
  localparam int REG_W = CNT_W + MODE_W;

  logic [REG_W-1:0]  stage;
  logic [CNT_W-1:0]  cnt;
  logic [MODE_W-1:0] mode;
  logic              phase, run;

  sqp_cfg_stage #(.REG_W(REG_W)) u_stage (
    .clk       (clk),
    .wr_en_i   (wr_en_i),
    .wr_hi_i   (wr_hi_i),
    .wr_data_i (wr_data_i),
    .stage_o   (stage)
  );

  sqp_down_core #(.CNT_W(CNT_W)) u_core (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_i       (tick_i),
    .cmd_valid_i  (cmd_valid_i),
    .cmd_i        (cmd_i),
    .stage_len_i  (stage[CNT_W-1:0]),
    .stage_mode_i (stage[REG_W-1:CNT_W]),
    .cnt_o        (cnt),
    .mode_o       (mode),
    .phase_o      (phase),
    .run_o        (run)
  );

  sqp_out_shaper #(.CNT_W(CNT_W)) u_shaper (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_i       (run),
    .phase_i     (phase),
    .cnt_i       (cnt),
    .mode_i      (mode),
    .timer_out_o (timer_out_o)
  );

  assign cnt_rd_o = {mode, cnt};
endmodule

// File: tb/sqp_timer_tb.sv
module sqp_timer_tb;
  localparam int WATCHDOG = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic        wr_hi_i = 1'b0;
  logic [7:0]  wr_data_i = '0;
  logic        cmd_valid_i = 1'b0;
  logic [1:0]  cmd_i = '0;
  logic        timer_out_o;
  logic [15:0] cnt_rd_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  int cur_n;
  logic [1:0] cur_m;
  int cur_k;

  always #2 clk = ~clk;

  sqp_timer u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .wr_hi_i(wr_hi_i), .wr_data_i(wr_data_i), .cmd_valid_i(cmd_valid_i),
    .cmd_i(cmd_i), .timer_out_o(timer_out_o), .cnt_rd_o(cnt_rd_o)
  );

  // Expected {out, mode, count} after k strobes since a legal start.
  function automatic logic [16:0] model(int n, logic [1:0] m, int k);
    int h, p, c;
    logic o;
    h = (n + 1) / 2;
    if (!m[0] && k >= n) return {1'b1, m, 14'd2};
    p = m[0] ? (k % n) : k;
    if (p < h) c = n - 2 * p;
    else       c = (n & ~1) - 2 * (p - h);
    o = m[1] ? (p != n - 1) : (p < h);
    return {o, m, 14'(c)};
  endfunction

  task automatic chk(string req, logic [16:0] act, logic [16:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [16:0] obs();
    return {timer_out_o, cnt_rd_o};
  endfunction

  task automatic wr_reg(input logic [15:0] v);
    wr_en_i = 1; wr_hi_i = 0; wr_data_i = v[7:0];
    @(negedge clk);
    wr_hi_i = 1; wr_data_i = v[15:8];
    @(negedge clk);
    wr_en_i = 0; wr_hi_i = 0;
  endtask

  task automatic issue(input logic [1:0] c, input bit with_tick);
    cmd_valid_i = 1; cmd_i = c; tick_i = with_tick;
    @(negedge clk);
    cmd_valid_i = 0; cmd_i = 0; tick_i = 0;
  endtask

  task automatic strobe();
    tick_i = 1;
    @(negedge clk);
    tick_i = 0;
  endtask

  task automatic start_cfg(int n, logic [1:0] m);
    wr_reg({m, 14'(n)});
    issue(2'b11, 0);
    cur_n = n; cur_m = m; cur_k = 0;
  endtask

  task automatic tick_chk(string req);
    strobe();
    cur_k++;
    chk(req, obs(), model(cur_n, cur_m, cur_k));
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [16:0] saved;
    void'($urandom(32'h5a17));
    repeat (3) @(negedge clk);
    chk("R12 reset output", {16'h0, timer_out_o}, 17'h1);
    rst_n = 1;
    @(negedge clk);
    chk("R9 idle output", {16'h0, timer_out_o}, 17'h1);

    // R1 R2 R3 R4 R5: single square cycle, n = 9
    start_cfg(9, 2'b00);
    chk("R2 start load", obs(), {1'b1, 16'h0009});
    for (int i = 0; i < 11; i++) tick_chk("R4 R5 square one-shot n=9");

    // R6: reloading square wave
    start_cfg(5, 2'b01);
    for (int i = 0; i < 12; i++) tick_chk("R6 reload square n=5");

    // R7: pulse one-shot and repeating
    start_cfg(4, 2'b10);
    for (int i = 0; i < 6; i++) tick_chk("R7 pulse one-shot n=4");
    start_cfg(3, 2'b11);
    for (int i = 0; i < 8; i++) tick_chk("R7 pulse repeat n=3");

    // R8: staged write while running is held until START
    start_cfg(6, 2'b01);
    tick_chk("R8 pre"); tick_chk("R8 pre");
    wr_reg({2'b10, 14'd20});
    chk("R8 write held", obs(), model(cur_n, cur_m, cur_k));
    tick_chk("R8 old values"); tick_chk("R8 old values");
    issue(2'b11, 0);
    cur_n = 20; cur_m = 2'b10; cur_k = 0;
    chk("R8 restart new", obs(), model(20, 2'b10, 0));
    for (int i = 0; i < 4; i++) tick_chk("R8 new values");

    // R9: STOP freezes
    issue(2'b01, 0);
    saved = obs();
    chk("R9 stop output", saved, {1'b1, saved[15:0]});
    strobe(); strobe();
    chk("R9 stop frozen", obs(), saved);

    // R10: deferred stop in reload mode
    start_cfg(4, 2'b01);
    tick_chk("R10 pre");
    issue(2'b10, 0);
    chk("R10 still running", obs(), model(4, 2'b01, 1));
    tick_chk("R10 finishing"); tick_chk("R10 finishing");
    strobe();
    chk("R10 stopped at tc", obs(), {1'b1, 2'b01, 14'd2});
    strobe();
    chk("R10 stays stopped", obs(), {1'b1, 2'b01, 14'd2});

    // R11: illegal lengths
    saved = obs();
    wr_reg({2'b11, 14'd1});
    issue(2'b11, 0);
    strobe();
    chk("R11 length 1", obs(), {1'b1, saved[15:0]});
    wr_reg({2'b00, 14'd0});
    issue(2'b11, 0);
    strobe();
    chk("R11 length 0", obs(), {1'b1, saved[15:0]});

    // R12: reset mid-count keeps counter
    start_cfg(10, 2'b01);
    tick_chk("R12 pre"); tick_chk("R12 pre"); tick_chk("R12 pre");
    saved = obs();
    rst_n = 0; tick_i = 1;
    @(negedge clk);
    rst_n = 1; tick_i = 0;
    chk("R12 reset keeps count", obs(), {1'b1, saved[15:0]});
    strobe(); strobe();
    chk("R12 no count after reset", obs(), {1'b1, saved[15:0]});
    issue(2'b11, 0);
    cur_k = 0;
    chk("R12 restart", obs(), model(10, 2'b01, 0));

    // R13: command and strobe in one cycle
    start_cfg(6, 2'b01);
    tick_chk("R13 pre"); tick_chk("R13 pre");
    issue(2'b01, 1);
    chk("R13 stop beats tick", obs(), {1'b1, model(6, 2'b01, 2)});
    issue(2'b11, 1);
    cur_k = 0;
    chk("R13 start beats tick", obs(), model(6, 2'b01, 0));
    for (int i = 0; i < 5; i++) tick_chk("R13 run");
    issue(2'b10, 1);
    chk("R13 deferred stop at tc", obs(), {1'b1, 2'b01, 14'd2});

    // Random runs: R3 R4 R6 R7
    for (int t = 0; t < 24; t++) begin
      int n, nt;
      logic [1:0] m;
      n = $urandom_range(2, 40);
      m = 2'($urandom_range(0, 3));
      nt = $urandom_range(1, 2 * n + 2);
      start_cfg(n, m);
      chk("R2 random start", obs(), model(n, m, 0));
      for (int i = 0; i < nt; i++) begin
        repeat ($urandom_range(0, 2)) @(negedge clk);
        tick_chk("R3 R4 R6 R7 random");
      end
    end

    done = 1;
    summary();
    $finish;
  end
endmodule